// File: doc/BRIEF.md
# Serial Flash Continuous-Read Command Front End

This block is the device-side command parser of a serial flash that serves dual-lane and quad-lane I/O reads. It runs on the system clock `clk`. A one-cycle strobe `sclk_rise` marks each rising edge of the serial clock, and bits are taken from `io_in` only on strobes while `cs_n` is low. A fresh transaction starts with an opcode that arrives one bit per clock. For a read, the parser gathers the 24-bit start address and the 8 mode bits over two or four lanes, waits out the dummy clocks that belong to that read, and then presents a read request to the memory side through a valid/ready pair.

Reads can skip their opcode. When the mode bits of a read carry the arming pattern, the parser remembers the read type. Every later transaction then begins straight at the address phase, and ordinary opcodes are not decoded. The device has no reset pin, so an all-ones byte on lane 0 is the only way to disarm this state. A high-performance-mode entry command is also decoded. After it, 24 dummy clocks follow, and then a one-cycle notification is given.

The serial-clock strobe must come at least one `clk` cycle after `cs_n` falls. `cs_n` must stay high for at least two `clk` cycles between transactions.

Top module: `sfr_crm_frontend`

## Requirements
- R1: After reset, `cont_armed`, `req_valid` and `hpm_enter` are 0, and the next transaction is parsed as an opcode.
- R2: Opcodes arrive MSB first on `io_in[0]`. Opcode BBh is a dual read: 16 clocks carry the address (bits 23..0) and then the mode bits, 2 bits per clock with `io_in[1]` holding the higher bit of each pair. `io_in[3:2]` are ignored. There are no dummy clocks. `req_valid` rises after the last of these clocks with `req_width` = 01.
- R3: Opcode EBh is a quad read: 8 clocks of 4 bits, with `io_in[3]` holding the highest bit, then 4 dummy clocks. `req_valid` rises after the 4th dummy clock with `req_width` = 10 and not earlier.
- R4: Opcode E7h is a quad read with 2 dummy clocks. `req_valid` rises after the 2nd dummy clock with `req_width` = 10.
- R5: When the mode byte of a read is complete, `cont_armed` becomes 1 if its upper nibble is 1010b and 0 otherwise. This applies to reads that skipped their opcode as well.
- R6: While `cont_armed` is 1, a new transaction has no opcode. Its first clocks are address bits at the lane width and dummy count of the read that armed the mode.
- R7: While armed, if `io_in[0]` is 1 on each of the first 8 clocks of a transaction, `cont_armed` clears and no request is issued. `io_in[3:1]` do not matter. Opcodes are decoded again afterwards.
- R8: Opcode FFh in an unarmed transaction leaves `cont_armed` at 0 and issues no request.
- R9: Opcode A3h followed by 24 clocks drives `hpm_enter` high for exactly one cycle, after the 24th clock, and issues no request.
- R10: Raising `cs_n` mid-command abandons it with no request. The value of `cont_armed` is kept.
- R11: Once raised, `req_valid`, `req_addr` and `req_width` hold until a cycle with `req_ready` high. `req_valid` is then 0 in the next cycle.
- R12: Any other opcode is ignored, along with the rest of the transaction until `cs_n` rises. `cont_armed` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk_rise | input | 1 | One-cycle strobe per serial clock rising edge |
| io_in | input | 4 | Serial data lanes IO3..IO0 |
| req_ready | input | 1 | Memory side accepts the read request |
| req_valid | output | 1 | Read request pending |
| req_addr | output | ADDR_W | Start address of the read |
| req_width | output | 2 | Lane width: 01 dual, 10 quad |
| cont_armed | output | 1 | Opcode-skip mode is armed |
| hpm_enter | output | 1 | Pulse: high-performance entry completed |

## Verification
The checker watches several properties on every cycle. A request may only begin on a serial strobe inside an active transaction. A pending request keeps its address and width until it is accepted. The width code is always dual or quad. The armed flag changes only on a serial strobe, and the high-performance notice lasts a single cycle. Other behaviours can only be shown by the bench's scenarios. These are the exact clock on which each read type fires, the lane ordering of address bits, the arming decided by the mode nibble, opcode-skipping while armed, the all-ones exit, aborts and ignored opcodes.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    localparam int MODE_W     = 8;
    localparam int HPM_CLOCKS = 24;
    localparam int DMY_DUAL   = 0;
    localparam int DMY_QUAD   = 4;
    localparam int DMY_QWORD  = 2;

    localparam logic [7:0] OPC_DUAL_IO   = 8'hBB;
    localparam logic [7:0] OPC_QUAD_IO   = 8'hEB;
    localparam logic [7:0] OPC_QUAD_WORD = 8'hE7;
    localparam logic [7:0] OPC_HIPERF    = 8'hA3;
    localparam logic [7:0] OPC_CRM_EXIT  = 8'hFF;
    localparam logic [3:0] ARM_NIBBLE    = 4'hA;

    typedef enum logic [1:0] {
        BUS_SINGLE = 2'd0,
        BUS_DUAL   = 2'd1,
        BUS_QUAD   = 2'd2
    } bus_w_e;

    typedef enum logic [1:0] {
        RD_DUAL  = 2'd0,
        RD_QUAD  = 2'd1,
        RD_QWORD = 2'd2
    } rd_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DUMMY,
        ST_HPM,
        ST_DRAIN
    } fe_state_e;

    function automatic bus_w_e kind_bus(rd_kind_e k);
        return (k == RD_DUAL) ? BUS_DUAL : BUS_QUAD;
    endfunction

    function automatic int kind_dummy(rd_kind_e k);
        case (k)
            RD_QUAD:  return DMY_QUAD;
            RD_QWORD: return DMY_QWORD;
            default:  return DMY_DUAL;
        endcase
    endfunction

endpackage

// File: rtl/sfr_lane_shift.sv
module sfr_lane_shift
    import sfr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         shift,
    input  bus_w_e       bus,
    input  logic [3:0]   io,
    output logic [W-1:0] q,
    output logic [W-1:0] nxt
);

    always_comb begin
        case (bus)
            BUS_QUAD: nxt = {q[W-5:0], io[3:0]};
            BUS_DUAL: nxt = {q[W-3:0], io[1:0]};
            default:  nxt = {q[W-2:0], io[0]};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= '0;
        else if (shift)
            q <= nxt;
    end

endmodule

// File: rtl/sfr_req_hold.sv
module sfr_req_hold
    import sfr_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic [AW-1:0] fire_addr,
    input  bus_w_e        fire_bus,
    input  logic          ready,
    output logic          valid,
    output logic [AW-1:0] addr,
    output bus_w_e        bus
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            addr  <= '0;
            bus   <= BUS_SINGLE;
        end else if (fire) begin
            valid <= 1'b1;
            addr  <= fire_addr;
            bus   <= fire_bus;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/sfr_crm_frontend.sv
module sfr_crm_frontend
    import sfr_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk_rise,
    input  logic [3:0]        io_in,
    input  logic              req_ready,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [1:0]        req_width,
    output logic              cont_armed,
    output logic              hpm_enter
);

    localparam int WORD_W    = ADDR_W + MODE_W;
    localparam int CNT_W     = $clog2(WORD_W + HPM_CLOCKS + 1);
    localparam int CLK_DUAL  = WORD_W / 2;
    localparam int CLK_QUAD  = WORD_W / 4;
    localparam int SKIP_WIN  = 8;

    fe_state_e          state;
    rd_kind_e           kind;
    logic [CNT_W-1:0]   cnt;
    logic [6:0]         opc;
    logic               ffok;
    logic               skip;
    logic               cont;
    logic               hpm_q;
    logic [ADDR_W-1:0]  addr_hold;

    logic               step;
    logic [7:0]         opc_nxt;
    bus_w_e             cur_bus;
    logic [WORD_W-1:0]  sh_q;
    logic [WORD_W-1:0]  sh_nxt;
    logic [CNT_W-1:0]   addr_last;
    logic [CNT_W-1:0]   dummy_n;
    logic               ff_abort;
    logic               addr_done;
    logic               fire;
    logic [ADDR_W-1:0]  fire_addr;
    logic [MODE_W-1:0]  mode_bits;
    bus_w_e             out_bus;

    assign step      = sclk_rise && !cs_n;
    assign opc_nxt   = {opc, io_in[0]};
    assign cur_bus   = (state == ST_ADDR) ? kind_bus(kind) : BUS_SINGLE;
    assign addr_last = (kind == RD_DUAL) ? CNT_W'(CLK_DUAL - 1) : CNT_W'(CLK_QUAD - 1);
    assign dummy_n   = CNT_W'(kind_dummy(kind));
    assign mode_bits = sh_nxt[MODE_W-1:0];

    // opcode-free transaction: all-ones on lane 0 over the first byte disarms
    assign ff_abort  = step && (state == ST_ADDR) && skip &&
                       (cnt == CNT_W'(SKIP_WIN - 1)) && ffok && io_in[0];
    assign addr_done = step && (state == ST_ADDR) && (cnt == addr_last) && !ff_abort;
    assign fire      = (addr_done && (dummy_n == '0)) ||
                       (step && (state == ST_DUMMY) && (cnt == dummy_n - 1'b1));
    assign fire_addr = (state == ST_ADDR) ? sh_nxt[WORD_W-1:MODE_W] : addr_hold;

    sfr_lane_shift #(.W(WORD_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .clr   (state == ST_IDLE),
        .shift (step && (state == ST_ADDR)),
        .bus   (cur_bus),
        .io    (io_in),
        .q     (sh_q),
        .nxt   (sh_nxt)
    );

    sfr_req_hold #(.AW(ADDR_W)) u_req (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .fire_addr (fire_addr),
        .fire_bus  (kind_bus(kind)),
        .ready     (req_ready),
        .valid     (req_valid),
        .addr      (req_addr),
        .bus       (out_bus)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            kind      <= RD_DUAL;
            cnt       <= '0;
            opc       <= '0;
            ffok      <= 1'b0;
            skip      <= 1'b0;
            cont      <= 1'b0;
            hpm_q     <= 1'b0;
            addr_hold <= '0;
        end else begin
            hpm_q <= 1'b0;
            if (cs_n) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: begin
                        cnt   <= '0;
                        ffok  <= 1'b1;
                        skip  <= cont;
                        state <= cont ? ST_ADDR : ST_OPC;
                    end
                    ST_OPC: if (sclk_rise) begin
                        opc <= opc_nxt[6:0];
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(7)) begin
                            cnt <= '0;
                            case (opc_nxt)
                                OPC_DUAL_IO:   begin kind <= RD_DUAL;  state <= ST_ADDR; end
                                OPC_QUAD_IO:   begin kind <= RD_QUAD;  state <= ST_ADDR; end
                                OPC_QUAD_WORD: begin kind <= RD_QWORD; state <= ST_ADDR; end
                                OPC_HIPERF:    state <= ST_HPM;
                                OPC_CRM_EXIT:  begin cont <= 1'b0; state <= ST_DRAIN; end
                                default:       state <= ST_DRAIN;
                            endcase
                        end
                    end
                    ST_ADDR: if (sclk_rise) begin
                        cnt <= cnt + 1'b1;
                        if (cnt < CNT_W'(SKIP_WIN))
                            ffok <= ffok & io_in[0];
                        if (ff_abort) begin
                            cont  <= 1'b0;
                            state <= ST_DRAIN;
                        end else if (addr_done) begin
                            cont      <= (mode_bits[MODE_W-1 -: 4] == ARM_NIBBLE);
                            addr_hold <= sh_nxt[WORD_W-1:MODE_W];
                            cnt       <= '0;
                            state     <= (dummy_n == '0) ? ST_DRAIN : ST_DUMMY;
                        end
                    end
                    ST_DUMMY: if (sclk_rise) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == dummy_n - 1'b1)
                            state <= ST_DRAIN;
                    end
                    ST_HPM: if (sclk_rise) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(HPM_CLOCKS - 1)) begin
                            hpm_q <= 1'b1;
                            state <= ST_DRAIN;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign req_width  = out_bus;
    assign cont_armed = cont;
    assign hpm_enter  = hpm_q;

endmodule

// File: rtl/sfr_crm_checker.sv
module sfr_crm_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              sclk_rise,
    input logic              req_ready,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_width,
    input logic              cont_armed,
    input logic              hpm_enter
);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!cont_armed && !req_valid && !hpm_enter));

    assert_width_code_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_width == 2'b01 || req_width == 2'b10));

    assert_arm_on_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(cont_armed) |-> $past(sclk_rise && !cs_n));

    assert_hpm_single_R9: assert property (@(posedge clk) disable iff (rst)
        hpm_enter |=> !hpm_enter);

    assert_req_in_frame_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) |-> $past(sclk_rise && !cs_n));

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_width)));

endmodule

bind sfr_crm_frontend sfr_crm_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .sclk_rise  (sclk_rise),
    .req_ready  (req_ready),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_width  (req_width),
    .cont_armed (cont_armed),
    .hpm_enter  (hpm_enter)
);

// File: tb/tb_sfr_crm_frontend.sv
`timescale 1ns/1ps
module tb_sfr_crm_frontend;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk_rise = 1'b0;
    logic [3:0]  io_in = 4'h0;
    logic        req_ready = 1'b0;
    logic        req_valid;
    logic [23:0] req_addr;
    logic [1:0]  req_width;
    logic        cont_armed;
    logic        hpm_enter;

    int checks = 0;
    int errors = 0;
    bit m_cont = 1'b0;
    int m_kind = 0;

    always #2.5 clk = ~clk;

    sfr_crm_frontend #(.ADDR_W(24)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk_rise(sclk_rise), .io_in(io_in),
        .req_ready(req_ready), .req_valid(req_valid), .req_addr(req_addr),
        .req_width(req_width), .cont_armed(cont_armed), .hpm_enter(hpm_enter)
    );

    function automatic logic [7:0] op_of(int k);
        return (k == 0) ? 8'hBB : (k == 1) ? 8'hEB : 8'hE7;
    endfunction
    function automatic int dummy_of(int k);
        return (k == 0) ? 0 : (k == 1) ? 4 : 2;
    endfunction
    function automatic logic [1:0] width_of(int k);
        return (k == 0) ? 2'b01 : 2'b10;
    endfunction
    function automatic string tag_of(int k, bit armed);
        if (armed) return "R6";
        return (k == 0) ? "R2" : (k == 1) ? "R3" : "R4";
    endfunction
    // lane-0 bits of the first 8 clocks of an opcode-free read, all ones?
    function automatic bit collides(int k, logic [31:0] w);
        bit all1 = 1'b1;
        for (int i = 0; i < 8; i++)
            all1 &= (k == 0) ? w[30-2*i] : w[28-4*i];
        return all1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clk_bit(input logic [3:0] v);
        io_in = v;
        sclk_rise = 1'b1;
        @(negedge clk);
        sclk_rise = 1'b0;
    endtask
    task automatic cs_low();
        cs_n = 1'b0;
        @(negedge clk);
    endtask
    task automatic cs_high();
        cs_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask
    task automatic send_op(input logic [7:0] op);
        for (int i = 7; i >= 0; i--)
            clk_bit({3'($urandom), op[i]});
    endtask

    task automatic do_read(input int k, input logic [23:0] a, input logic [7:0] m);
        logic [3:0]  seq[64];
        int          n = 0;
        int          lanes = (k == 0) ? 2 : 4;
        bit          armed = m_cont;
        string       tg;
        logic [31:0] w;
        if (armed) k = m_kind;
        lanes = (k == 0) ? 2 : 4;
        tg = tag_of(k, armed);
        w = {a, m};
        if (armed && collides(k, w)) begin
            a = a ^ ((k == 0) ? 24'h400000 : 24'h100000);
            w = {a, m};
        end
        if (!armed)
            for (int i = 7; i >= 0; i--) begin seq[n] = {3'($urandom), op_of(k)[i]}; n++; end
        for (int i = 0; i < 32 / lanes; i++) begin
            if (lanes == 2) seq[n] = {2'($urandom), w[31-2*i -: 2]};
            else            seq[n] = w[31-4*i -: 4];
            n++;
        end
        for (int i = 0; i < dummy_of(k); i++) begin seq[n] = 4'($urandom); n++; end
        cs_low();
        for (int i = 0; i < n - 1; i++) clk_bit(seq[i]);
        chk({tg, " no request before last clock"}, {31'd0, req_valid}, 32'd0);
        clk_bit(seq[n-1]);
        chk({tg, " request raised"}, {31'd0, req_valid}, 32'd1);
        chk({tg, " address"}, {8'd0, req_addr}, {8'd0, a});
        chk({tg, " width"}, {30'd0, req_width}, {30'd0, width_of(k)});
        m_cont = (m[7:4] == 4'hA);
        m_kind = k;
        chk("R5 arm state after mode byte", {31'd0, cont_armed}, {31'd0, m_cont});
        @(negedge clk); @(negedge clk);
        chk("R11 held while not ready", {7'd0, req_valid, req_addr}, {7'd0, 1'b1, a});
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        chk("R11 drops after accept", {31'd0, req_valid}, 32'd0);
        cs_high();
    endtask

    initial begin
        #500us;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset armed", {31'd0, cont_armed}, 32'd0);
        chk("R1 reset valid", {31'd0, req_valid}, 32'd0);
        chk("R1 reset hpm", {31'd0, hpm_enter}, 32'd0);

        // directed reads of each kind, unarmed
        do_read(0, 24'h123456, 8'h00);
        do_read(1, 24'hABCDEF, 8'h3C);
        do_read(2, 24'h00FF01, 8'h5F);

        // R8: exit opcode while unarmed
        cs_low(); send_op(8'hFF); cs_high();
        chk("R8 exit when unarmed", {30'd0, cont_armed, req_valid}, 32'd0);

        // arm with quad, read opcode-free, then abort mid-address
        do_read(1, 24'h0A0B0C, 8'hA5);
        do_read(1, 24'h112233, 8'hA0);
        cs_low();
        for (int i = 0; i < 3; i++) clk_bit(4'($urandom));
        cs_high();
        chk("R10 abort keeps arm", {30'd0, cont_armed, req_valid}, 32'd2);

        // R7: all-ones exit while armed, upper lanes random
        cs_low();
        for (int i = 0; i < 8; i++) clk_bit({3'($urandom), 1'b1});
        cs_high();
        m_cont = 1'b0;
        chk("R7 exit clears arm", {30'd0, cont_armed, req_valid}, 32'd0);
        do_read(0, 24'hFEDCBA, 8'hA1);
        do_read(0, 24'h654321, 8'h7E);
        chk("R5 non-matching mode disarms", {31'd0, cont_armed}, 32'd0);

        // R9: high-performance entry
        cs_low(); send_op(8'hA3);
        for (int i = 0; i < 23; i++) clk_bit(4'($urandom));
        chk("R9 no pulse early", {31'd0, hpm_enter}, 32'd0);
        clk_bit(4'($urandom));
        chk("R9 pulse", {30'd0, hpm_enter, req_valid}, 32'd2);
        @(negedge clk);
        chk("R9 pulse single", {31'd0, hpm_enter}, 32'd0);
        cs_high();

        // R12: unknown opcode then junk
        cs_low(); send_op(8'h03);
        for (int i = 0; i < 32; i++) clk_bit(4'($urandom));
        chk("R12 unknown ignored", {30'd0, cont_armed, req_valid}, 32'd0);
        cs_high();

        // R10 abort of an unarmed read
        cs_low(); send_op(8'hBB);
        for (int i = 0; i < 5; i++) clk_bit(4'($urandom));
        cs_high();
        chk("R10 abort no request", {31'd0, req_valid}, 32'd0);

        // random mix
        for (int it = 0; it < 40; it++) begin
            logic [7:0] md = 8'($urandom);
            if ($urandom % 2) md[7:4] = 4'hA;
            do_read(int'($urandom % 3), 24'($urandom), md);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule